// File: doc/BRIEF.md
# Byte-Wide GPIO Port Control Registers

This block holds the control state for four general-purpose I/O ports behind a small synchronous register bus. For each port it keeps a data-out byte, an output-mode byte and a direction byte, and it returns a synchronized snapshot of that port's input pins. It also keeps two select registers that steer pins to dedicated functions. All register contents drive plain output vectors continuously, so pad logic elsewhere can use them directly.

The bus carries one request per cycle, with no back-pressure. The block accepts every request in the cycle it is presented. It returns a one-cycle response on the next cycle. The response carries a valid strobe, registered read data and an error flag. Illegal accesses are reported through that error flag and leave every register as it was. Illegal accesses are wrong-sized transfers, offsets outside the map, writes to input registers, reads of the port 3 input offset, and writes that set a bit the target register does not implement. Input pins come in on a flat vector and pass through a two-flop synchronizer.

Top module: `gpio_port_regs`

## Requirements
- R1: The map is: data-out for ports 0..3 at 0x00, 0x01, 0x04, 0x05; mode at 0x20, 0x21, 0x24, 0x25; direction at 0x60, 0x61, 0x64, 0x65; input at 0x80, 0x81, 0x84, 0x85; select A at 0x44; select B at 0x48. A legal write stores the byte, and a legal read returns the stored byte.
- R2: After reset, every data-out, mode, direction and input register reads 0x00, except port 2 mode, which reads 0xFF. Select A reads 0x00 and select B reads 0x0F.
- R3: `req_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Any code other than 0 gives an error response and changes no register.
- R4: A request to any offset not listed in R1 gives an error response and changes no register.
- R5: For port 3, the data-out, mode and direction registers implement only bits 1:0. A write with any of bits 7:2 set gives an error and leaves the register unchanged.
- R6: The mode registers of ports 0 and 1 implement only bit 0. A write with any of bits 7:1 set gives an error and leaves the register unchanged. The port 2 mode register accepts all 8 bits.
- R7: Select A implements bits 1:0 and select B implements bits 3:0. A write that sets any other bit gives an error and leaves the register unchanged.
- R8: A write to any input offset gives an error and has no effect on the value later read there.
- R9: A read of the input offset of ports 0..2 returns `pins_i[8p+7:8p]` after two clocks of synchronization. A read of the port 3 input offset gives an error.
- R10: Every request gets exactly one response one cycle later. `rsp_valid` and `rsp_err` are high for that single cycle only. `rsp_rdata` is 0x00 for writes and for errors.
- R11: `port_out_o`, `port_mode_o`, `port_dir_o`, `sel_a_o` and `sel_b_o` always show the current register contents. Port p occupies bits 8p+7:8p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code (0 = byte) |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 8 | Registered read data |
| rsp_err | output | 1 | Error flag for the response |
| pins_i | input | 32 | Raw input pin levels, 8 per port |
| port_out_o | output | 32 | Data-out registers |
| port_mode_o | output | 32 | Output-mode registers |
| port_dir_o | output | 32 | Direction registers |
| sel_a_o | output | 8 | Select A register |
| sel_b_o | output | 8 | Select B register |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle response strobe, the error response to wrong-sized requests, unchanged state after an error, and the fact that no unimplemented bit of port 3, of the port 0/1 mode registers or of the select registers can ever become set. Other behaviour can only be shown by the bench's scenarios: which offsets decode, the exact reset values read back, the data returned by each read, and the latency from a pin change to a readable input value.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_OUT,
    TGT_MODE,
    TGT_DIR,
    TGT_PIN,
    TGT_SELA,
    TGT_SELB
  } tgt_e;

  localparam logic [1:0] SIZE_BYTE = 2'd0;

  localparam int OUT_BASE  = 'h00;
  localparam int MODE_BASE = 'h20;
  localparam int DIR_BASE  = 'h60;
  localparam int PIN_BASE  = 'h80;
  localparam int SELA_OFF  = 'h44;
  localparam int SELB_OFF  = 'h48;

  // Ports are laid out in pairs; each pair advances the offset by four.
  function automatic int port_rel(int p);
    return (p / 2) * 4 + (p % 2);
  endfunction

  // Bits a write may set; any other set bit rejects the write.
  function automatic logic [BYTE_W-1:0] wr_mask(tgt_e t, int p);
    case (t)
      TGT_OUT, TGT_DIR: return (p == 3) ? 8'h03 : 8'hFF;
      TGT_MODE: begin
        if (p <= 1) return 8'h01;
        else if (p == 3) return 8'h03;
        else return 8'hFF;
      end
      TGT_SELA: return 8'h03;
      TGT_SELB: return 8'h0F;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] mode_reset(int p);
    return (p == 2) ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [PIDX_W-1:0] port
);

  always_comb begin
    tgt  = TGT_NONE;
    port = '0;
    if (addr == ADDR_W'(SELA_OFF)) tgt = TGT_SELA;
    if (addr == ADDR_W'(SELB_OFF)) tgt = TGT_SELB;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(OUT_BASE + port_rel(p))) begin
        tgt = TGT_OUT;  port = PIDX_W'(p);
      end
      if (addr == ADDR_W'(MODE_BASE + port_rel(p))) begin
        tgt = TGT_MODE; port = PIDX_W'(p);
      end
      if (addr == ADDR_W'(DIR_BASE + port_rel(p))) begin
        tgt = TGT_DIR;  port = PIDX_W'(p);
      end
      if (addr == ADDR_W'(PIN_BASE + port_rel(p))) begin
        tgt = TGT_PIN;  port = PIDX_W'(p);
      end
    end
  end

endmodule

// File: rtl/gpio_access_policy.sv
module gpio_access_policy
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PIN_PORTS = 3,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  tgt_e              tgt,
  input  logic [PIDX_W-1:0] port,
  input  logic              is_write,
  input  logic [1:0]        size,
  input  logic [BYTE_W-1:0] wdata,
  output logic              reject
);

  logic [BYTE_W-1:0] mask;
  logic bad_size, unmapped, pin_write, pin_absent, reserved_set;

  always_comb begin
    mask         = wr_mask(tgt, int'(port));
    bad_size     = (size != SIZE_BYTE);
    unmapped     = (tgt == TGT_NONE);
    pin_write    = is_write && (tgt == TGT_PIN);
    pin_absent   = !is_write && (tgt == TGT_PIN) && (int'(port) >= PIN_PORTS);
    reserved_set = is_write && (tgt != TGT_PIN) && ((wdata & ~mask) != '0);
    reject       = bad_size || unmapped || pin_write || pin_absent || reserved_set;
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PIN_PORTS = 3,
  parameter int ADDR_W    = 8,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int VEC_W    = NUM_PORTS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [VEC_W-1:0]  pins_i,
  output logic [VEC_W-1:0]  port_out_o,
  output logic [VEC_W-1:0]  port_mode_o,
  output logic [VEC_W-1:0]  port_dir_o,
  output logic [BYTE_W-1:0] sel_a_o,
  output logic [BYTE_W-1:0] sel_b_o
);

  tgt_e              tgt;
  logic [PIDX_W-1:0] port;
  logic              reject;
  logic              wr_ok;
  logic [VEC_W-1:0]  pin_sync;
  logic [BYTE_W-1:0] rd_mux;

  gpio_addr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .tgt  (tgt),
    .port (port)
  );

  gpio_access_policy #(.NUM_PORTS(NUM_PORTS), .PIN_PORTS(PIN_PORTS)) u_pol (
    .tgt      (tgt),
    .port     (port),
    .is_write (req_write),
    .size     (req_size),
    .wdata    (req_wdata),
    .reject   (reject)
  );

  gpio_pin_sync #(.WIDTH(VEC_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pins_i),
    .synced (pin_sync)
  );

  assign wr_ok = req_valid && req_write && !reject;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [BYTE_W-1:0] out_r, mode_r, dir_r;
    logic hit;
    assign hit = wr_ok && (port == PIDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_r  <= '0;
        mode_r <= mode_reset(p);
        dir_r  <= '0;
      end else if (hit) begin
        if (tgt == TGT_OUT)  out_r  <= req_wdata;
        if (tgt == TGT_MODE) mode_r <= req_wdata;
        if (tgt == TGT_DIR)  dir_r  <= req_wdata;
      end
    end

    assign port_out_o [p*BYTE_W +: BYTE_W] = out_r;
    assign port_mode_o[p*BYTE_W +: BYTE_W] = mode_r;
    assign port_dir_o [p*BYTE_W +: BYTE_W] = dir_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_o <= 8'h00;
      sel_b_o <= 8'h0F;
    end else if (wr_ok) begin
      if (tgt == TGT_SELA) sel_a_o <= req_wdata;
      if (tgt == TGT_SELB) sel_b_o <= req_wdata;
    end
  end

  always_comb begin
    case (tgt)
      TGT_OUT:  rd_mux = port_out_o [int'(port)*BYTE_W +: BYTE_W];
      TGT_MODE: rd_mux = port_mode_o[int'(port)*BYTE_W +: BYTE_W];
      TGT_DIR:  rd_mux = port_dir_o [int'(port)*BYTE_W +: BYTE_W];
      TGT_PIN:  rd_mux = pin_sync   [int'(port)*BYTE_W +: BYTE_W];
      TGT_SELA: rd_mux = sel_a_o;
      TGT_SELB: rd_mux = sel_b_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && reject;
      rsp_rdata <= (req_valid && !req_write && !reject) ? rd_mux : '0;
    end
  end

  // R10: one response, exactly one cycle after each request
  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err));
  // R3: wrong-sized access errors and leaves state alone
  assert_bad_size_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SIZE_BYTE) |=> rsp_err);
  assert_bad_size_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SIZE_BYTE) |=>
      ($stable(port_out_o) && $stable(port_mode_o) && $stable(port_dir_o)
       && $stable(sel_a_o) && $stable(sel_b_o)));
  // R4: any rejected request leaves every register unchanged
  assert_err_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($stable(port_out_o) && $stable(port_mode_o) && $stable(port_dir_o)
                 && $stable(sel_a_o) && $stable(sel_b_o)));
  // R5: unimplemented bits of port 3 never become set
  assert_port3_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_out_o[31:26] == '0) && (port_mode_o[31:26] == '0) && (port_dir_o[31:26] == '0));
  // R6: port 0/1 mode registers hold only bit 0
  assert_mode01_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_mode_o[7:1] == '0) && (port_mode_o[15:9] == '0));
  // R7: select registers hold only their implemented bits
  assert_select_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_o[7:2] == '0) && (sel_b_o[7:4] == '0));

endmodule

// File: tb/tb_gpio_port_regs.sv
`timescale 1ns/1ps
module tb_gpio_port_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = 8'h00, req_wdata = 8'h00;
  logic        rsp_valid, rsp_err;
  logic [7:0]  rsp_rdata;
  logic [31:0] pins_i = 32'h0;
  logic [31:0] port_out_o, port_mode_o, port_dir_o;
  logic [7:0]  sel_a_o, sel_b_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_regs dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .pins_i(pins_i), .port_out_o(port_out_o), .port_mode_o(port_mode_o),
    .port_dir_o(port_dir_o), .sel_a_o(sel_a_o), .sel_b_o(sel_b_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; response sampled one cycle later, away from the edge.
  task automatic access(input logic w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [7:0] d, output logic [7:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic expect_read(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] rd; logic er;
    access(1'b0, 2'd0, a, 8'h00, rd, er);
    chk({req, " err"}, {31'b0, er}, 32'd0);
    chk({req, " data"}, {24'b0, rd}, {24'b0, exp});
  endtask

  task automatic expect_write(input string req, input logic [1:0] sz, input logic [7:0] a,
                              input logic [7:0] d, input logic exp_err);
    logic [7:0] rd; logic er;
    access(1'b1, sz, a, d, rd, er);
    chk({req, " err"}, {31'b0, er}, {31'b0, exp_err});
    chk({req, " wr rdata"}, {24'b0, rd}, 32'd0);
  endtask

  task automatic t_reset_R2;
    chk("R2 out vec", port_out_o, 32'h0);
    chk("R2 mode vec", port_mode_o, 32'h00FF_0000);
    chk("R2 dir vec", port_dir_o, 32'h0);
    chk("R2 sel vec", {sel_b_o, sel_a_o}, 32'h0F00);
    expect_read("R2 out0", 8'h00, 8'h00);
    expect_read("R2 mode2", 8'h24, 8'hFF);
    expect_read("R2 mode3", 8'h25, 8'h00);
    expect_read("R2 dir1", 8'h61, 8'h00);
    expect_read("R2 selA", 8'h44, 8'h00);
    expect_read("R2 selB", 8'h48, 8'h0F);
    expect_read("R2 pin0", 8'h80, 8'h00);
  endtask

  task automatic t_map_R1;
    expect_write("R1 out0", 2'd0, 8'h00, 8'h5A, 1'b0);
    expect_write("R1 out1", 2'd0, 8'h01, 8'hC3, 1'b0);
    expect_write("R1 out2", 2'd0, 8'h04, 8'h81, 1'b0);
    expect_write("R1 dir0", 2'd0, 8'h60, 8'hF0, 1'b0);
    expect_write("R1 dir2", 2'd0, 8'h64, 8'h3C, 1'b0);
    expect_write("R1 mode1", 2'd0, 8'h21, 8'h01, 1'b0);
    expect_read("R1 out0", 8'h00, 8'h5A);
    expect_read("R1 out1", 8'h01, 8'hC3);
    expect_read("R1 out2", 8'h04, 8'h81);
    expect_read("R1 dir0", 8'h60, 8'hF0);
    expect_read("R1 dir2", 8'h64, 8'h3C);
    expect_read("R1 mode1", 8'h21, 8'h01);
    chk("R11 out vec", port_out_o, 32'h0081_C35A);
    chk("R11 dir vec", port_dir_o, 32'h003C_00F0);
    chk("R11 mode vec", port_mode_o, 32'h00FF_0100);
  endtask

  task automatic t_size_R3;
    expect_write("R3 half", 2'd1, 8'h00, 8'h11, 1'b1);
    expect_write("R3 word", 2'd2, 8'h44, 8'h01, 1'b1);
    expect_write("R3 rsvd", 2'd3, 8'h60, 8'h00, 1'b1);
    expect_read("R3 out0 kept", 8'h00, 8'h5A);
    expect_read("R3 selA kept", 8'h44, 8'h00);
    chk("R3 dir vec kept", port_dir_o, 32'h003C_00F0);
  endtask

  task automatic t_unmapped_R4;
    logic [7:0] rd; logic er;
    access(1'b0, 2'd0, 8'h02, 8'h00, rd, er);
    chk("R4 rd 0x02 err", {31'b0, er}, 32'd1);
    chk("R4 rd 0x02 data", {24'b0, rd}, 32'd0);
    expect_write("R4 wr 0x40", 2'd0, 8'h40, 8'h01, 1'b1);
    expect_write("R4 wr 0x06", 2'd0, 8'h06, 8'hFF, 1'b1);
    chk("R4 out vec kept", port_out_o, 32'h0081_C35A);
    chk("R4 sel vec kept", {sel_b_o, sel_a_o}, 32'h0F00);
  endtask

  task automatic t_port3_R5;
    expect_write("R5 out3 bad", 2'd0, 8'h05, 8'h04, 1'b1);
    expect_write("R5 mode3 bad", 2'd0, 8'h25, 8'h80, 1'b1);
    expect_write("R5 dir3 bad", 2'd0, 8'h65, 8'hFF, 1'b1);
    expect_read("R5 out3 kept", 8'h05, 8'h00);
    expect_write("R5 out3 ok", 2'd0, 8'h05, 8'h03, 1'b0);
    expect_write("R5 dir3 ok", 2'd0, 8'h65, 8'h02, 1'b0);
    expect_write("R5 mode3 ok", 2'd0, 8'h25, 8'h01, 1'b0);
    expect_read("R5 out3", 8'h05, 8'h03);
    expect_read("R5 dir3", 8'h65, 8'h02);
    expect_read("R5 mode3", 8'h25, 8'h01);
    chk("R5 out vec", port_out_o[31:24], 32'h03);
  endtask

  task automatic t_mode_R6;
    expect_write("R6 mode0 bad", 2'd0, 8'h20, 8'h02, 1'b1);
    expect_write("R6 mode1 bad", 2'd0, 8'h21, 8'h81, 1'b1);
    expect_read("R6 mode1 kept", 8'h21, 8'h01);
    expect_write("R6 mode0 ok", 2'd0, 8'h20, 8'h01, 1'b0);
    expect_read("R6 mode0", 8'h20, 8'h01);
    expect_write("R6 mode2 full", 2'd0, 8'h24, 8'hA5, 1'b0);
    expect_read("R6 mode2", 8'h24, 8'hA5);
  endtask

  task automatic t_select_R7;
    expect_write("R7 selA bad", 2'd0, 8'h44, 8'h04, 1'b1);
    expect_write("R7 selB bad", 2'd0, 8'h48, 8'h10, 1'b1);
    chk("R7 sel kept", {sel_b_o, sel_a_o}, 32'h0F00);
    expect_write("R7 selA ok", 2'd0, 8'h44, 8'h02, 1'b0);
    expect_write("R7 selB ok", 2'd0, 8'h48, 8'h0A, 1'b0);
    expect_read("R7 selA", 8'h44, 8'h02);
    expect_read("R7 selB", 8'h48, 8'h0A);
    chk("R11 sel vec", {sel_b_o, sel_a_o}, 32'h0A02);
  endtask

  task automatic t_pins_R9;
    logic [7:0] rd; logic er;
    @(negedge clk);
    pins_i = 32'hEE_33_96_C5;
    repeat (2) @(negedge clk);
    expect_read("R9 pin0", 8'h80, 8'hC5);
    expect_read("R9 pin1", 8'h81, 8'h96);
    expect_read("R9 pin2", 8'h84, 8'h33);
    access(1'b0, 2'd0, 8'h85, 8'h00, rd, er);
    chk("R9 pin3 err", {31'b0, er}, 32'd1);
    chk("R9 pin3 data", {24'b0, rd}, 32'd0);
  endtask

  task automatic t_pin_write_R8;
    expect_write("R8 pin0 wr", 2'd0, 8'h80, 8'h00, 1'b1);
    expect_write("R8 pin2 wr", 2'd0, 8'h84, 8'hFF, 1'b1);
    expect_read("R8 pin0 kept", 8'h80, 8'hC5);
    expect_read("R8 pin2 kept", 8'h84, 8'h33);
  endtask

  task automatic t_timing_R10;
    @(negedge clk);
    chk("R10 idle valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10 idle err", {31'b0, rsp_err}, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 8'h10; req_wdata = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 err pulse", {30'b0, rsp_valid, rsp_err}, 32'd3);
    @(negedge clk);
    chk("R10 err drops", {30'b0, rsp_valid, rsp_err}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R2();
    t_map_R1();
    t_size_R3();
    t_unmapped_R4();
    t_port3_R5();
    t_mode_R6();
    t_select_R7();
    t_pins_R9();
    t_pin_write_R8();
    t_timing_R10();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule